// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block keeps a 1024-row asynchronous DRAM alive. After reset it holds off for a programmable start-up pause. It then runs a fixed number of warm-up refresh cycles and only afterwards signals that normal accesses may begin. From that point an interval timer adds one owed refresh per period. The period is sized so that every row is visited inside the retention window, for example one refresh per 15.6 µs for a 16 ms window.

Each owed refresh is executed by a strobe sequencer, and one of two forms is chosen by an input. In the first form, the column strobe is dropped before the row strobe, and the memory picks the row from its own counter. In the second form, only the row strobe is pulsed while a row counter held here drives the address lines. The sequencer uses the shared memory bus only after the access controller grants it. It keeps the request high until precharge is complete.

Refreshes that cannot run because the bus is busy are not lost. They accumulate in a small saturating debt counter. Once the debt passes a threshold, an urgency flag tells the access controller to favour refresh over new host traffic.

Top module: `dref_sched`

## Requirements
- R1: While reset is asserted and on the cycle after it, `ras_n`, `cas_n` and `we_n` are 1 and `bus_req`, `init_done`, `refresh_urgent` and `addr_en` are 0.
- R2: For the first PAUSE_CYC clock cycles after reset release, `bus_req` stays 0 and no strobe falls. `bus_req` rises on the cycle right after that pause.
- R3: Exactly WARMUP_CNT refresh cycles, in the form selected by `use_cbr`, run before `init_done` rises. `init_done` then stays 1 until reset.
- R4: With `use_cbr`=1, `cas_n` is 0 for at least CSR_CYC cycles before `ras_n` falls, stays 0 for the whole time `ras_n` is 0, and `we_n` is 1 throughout.
- R5: With `use_cbr`=0, `cas_n` stays 1. `addr_en` is 1, and `row_addr` is stable from one cycle before `ras_n` falls through the fall.
- R6: `ras_n` is 0 for exactly RAS_CYC cycles per refresh. Between pulses it is 1 for at least RP_CYC cycles.
- R7: In the row-strobe-only form, the row counter starts at 0 after reset, advances by one per refresh, and wraps from 1023 to 0.
- R8: After `init_done`, one refresh is owed every INTERVAL_CYC cycles. Owed refreshes withheld by a low `bus_gnt` are all run later, and the debt saturates at 2^DEBT_W−1.
- R9: A refresh starts only while `bus_gnt` is 1. `bus_req` is 1 whenever a strobe is low, and it is 0 when nothing is owed and the sequencer is idle.
- R10: `refresh_urgent` is 1 exactly when the debt exceeds URGENT_TH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| use_cbr | input | 1 | 1: internal-counter refresh form, 0: addressed row-strobe-only form |
| bus_gnt | input | 1 | Memory bus granted by the access controller |
| bus_req | output | 1 | Request for the memory bus, held through a refresh |
| refresh_urgent | output | 1 | Debt above threshold; refresh should win over host accesses |
| init_done | output | 1 | Start-up pause and warm-up complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr_en | output | 1 | Refresh row address is being driven |
| row_addr | output | ROW_W | Row address for the row-strobe-only form |

## Verification
The strobe sequencer is tried in both forms. The internal-counter form shows whether the column strobe leads and covers the row pulse. The addressed form, run past more than 1024 refreshes, shows that the column strobe stays idle and that the row address increments and wraps. The debt path is tried with the grant withheld across several intervals and then restored. The samples taken while withheld show when the urgency flag rises and that nothing starts without a grant. The count after the grant returns shows that no owed refresh was dropped and that saturation capped the debt.

// File: rtl/dref_pkg.sv
// Shared types for the DRAM refresh scheduler.
package dref_pkg;
    // Start-up phase of the scheduler.
    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_WARM  = 2'd1,
        PH_RUN   = 2'd2
    } dref_phase_e;

    // Strobe sequencer state.
    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_CASPRE = 3'd1,
        SQ_ROWSET = 3'd2,
        SQ_ACTIVE = 3'd3,
        SQ_PRECH  = 3'd4
    } dref_seq_e;
endpackage

// File: rtl/dref_timer.sv
// dref_timer: start-up pause, warm-up cycle count and refresh interval tick.
// Assumes PAUSE_CYC, INTERVAL_CYC and WARMUP_CNT are all at least 1.
// cyc_done pulses for one cycle at the end of each refresh cycle.
module dref_timer
    import dref_pkg::*;
#(
    parameter int PAUSE_CYC    = 10000,
    parameter int INTERVAL_CYC = 1560,
    parameter int WARMUP_CNT   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_done,
    output dref_phase_e phase,
    output logic        tick
);
    localparam int CNT_MAX = (PAUSE_CYC > INTERVAL_CYC) ? PAUSE_CYC : INTERVAL_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int WARM_W  = $clog2(WARMUP_CNT + 1);
    localparam logic [CNT_W-1:0]  PAUSE_LAST = CNT_W'(PAUSE_CYC - 1);
    localparam logic [CNT_W-1:0]  IVL_LAST   = CNT_W'(INTERVAL_CYC - 1);
    localparam logic [WARM_W-1:0] WARM_INIT  = WARM_W'(WARMUP_CNT);

    logic [CNT_W-1:0]  cnt;
    logic [WARM_W-1:0] warm_left;

    // Advance the phase and the shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_PAUSE;
            cnt       <= '0;
            warm_left <= WARM_INIT;
        end else begin
            case (phase)
                PH_PAUSE: begin
                    if (cnt == PAUSE_LAST) begin
                        phase <= PH_WARM;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_WARM: begin
                    if (cyc_done) begin
                        warm_left <= warm_left - WARM_W'(1);
                        if (warm_left == WARM_W'(1)) begin
                            phase <= PH_RUN;
                            cnt   <= '0;
                        end
                    end
                end
                PH_RUN: begin
                    cnt <= (cnt == IVL_LAST) ? '0 : cnt + CNT_W'(1);
                end
                default: phase <= PH_PAUSE;
            endcase
        end
    end

    // One owed refresh per elapsed interval once running.
    always_comb tick = (phase == PH_RUN) && (cnt == IVL_LAST);
endmodule

// File: rtl/dref_debt.sv
// dref_debt: saturating count of refreshes owed but not yet run.
// Assumes add and pay are single-cycle pulses; both at once leave it unchanged.
module dref_debt #(
    parameter int DEBT_W    = 3,
    parameter int URGENT_TH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic pay,
    output logic owed,
    output logic urgent
);
    localparam logic [DEBT_W-1:0] DEBT_MAX = '1;
    localparam logic [DEBT_W-1:0] TH       = DEBT_W'(URGENT_TH);

    logic [DEBT_W-1:0] debt;

    // Add on each interval tick, remove on each completed refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt <= '0;
        end else begin
            case ({add, pay})
                2'b10:   if (debt != DEBT_MAX) debt <= debt + DEBT_W'(1);
                2'b01:   if (debt != '0)       debt <= debt - DEBT_W'(1);
                default: debt <= debt;
            endcase
        end
    end

    // Status derived from the count.
    always_comb begin
        owed   = (debt != '0);
        urgent = (debt > TH);
    end
endmodule

// File: rtl/dref_strobe.sv
// dref_strobe: drives one refresh cycle on the strobes once start is seen.
// Internal-counter form: CAS low CSR_CYC cycles, then RAS low RAS_CYC cycles
// with CAS still low. Addressed form: one address setup cycle, then RAS low
// RAS_CYC cycles with CAS high. Both end with RP_CYC cycles of precharge.
// Assumes start is only raised while busy is low; all cycle counts >= 1.
module dref_strobe
    import dref_pkg::*;
#(
    parameter int ROW_W   = 10,
    parameter int CSR_CYC = 1,
    parameter int RAS_CYC = 6,
    parameter int RP_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             use_cbr,
    output logic             ras_n,
    output logic             cas_n,
    output logic             addr_en,
    output logic [ROW_W-1:0] row_addr,
    output logic             busy,
    output logic             done
);
    localparam int T_MAX0 = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
    localparam int T_MAX  = (T_MAX0 > RP_CYC) ? T_MAX0 : RP_CYC;
    localparam int TW     = $clog2(T_MAX + 1);
    localparam logic [TW-1:0] CSR_LAST = TW'(CSR_CYC - 1);
    localparam logic [TW-1:0] RAS_LAST = TW'(RAS_CYC - 1);
    localparam logic [TW-1:0] RP_LAST  = TW'(RP_CYC - 1);

    dref_seq_e        st;
    logic [TW-1:0]    cnt;
    logic             mode_cbr;
    logic [ROW_W-1:0] row_q;

    // Sequence state, phase timer, latched form and row counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_IDLE;
            cnt      <= '0;
            mode_cbr <= 1'b1;
            row_q    <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        mode_cbr <= use_cbr;
                        if (use_cbr) begin
                            st  <= SQ_CASPRE;
                            cnt <= CSR_LAST;
                        end else begin
                            st <= SQ_ROWSET;
                        end
                    end
                end
                SQ_CASPRE: begin
                    if (cnt == '0) begin
                        st  <= SQ_ACTIVE;
                        cnt <= RAS_LAST;
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                SQ_ROWSET: begin
                    st  <= SQ_ACTIVE;
                    cnt <= RAS_LAST;
                end
                SQ_ACTIVE: begin
                    if (cnt == '0) begin
                        st  <= SQ_PRECH;
                        cnt <= RP_LAST;
                        if (!mode_cbr) row_q <= row_q + ROW_W'(1);
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                SQ_PRECH: begin
                    if (cnt == '0) st <= SQ_IDLE;
                    else           cnt <= cnt - TW'(1);
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Strobe and address decode from the registered state.
    always_comb begin
        ras_n    = (st != SQ_ACTIVE);
        cas_n    = !((st == SQ_CASPRE) || ((st == SQ_ACTIVE) && mode_cbr));
        addr_en  = !mode_cbr && ((st == SQ_ROWSET) || (st == SQ_ACTIVE));
        row_addr = addr_en ? row_q : '0;
        busy     = (st != SQ_IDLE);
        done     = (st == SQ_PRECH) && (cnt == '0);
    end
endmodule

// File: rtl/dref_sched.sv
// dref_sched: refresh and start-up scheduler for a 1024-row DRAM.
// Waits PAUSE_CYC after reset, runs WARMUP_CNT refreshes, then owes one
// refresh per INTERVAL_CYC and runs owed refreshes when the bus is granted.
// Assumes the access controller grants the bus only between its own
// accesses and leaves it granted while bus_req stays high.
module dref_sched
    import dref_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int PAUSE_CYC    = 10000,
    parameter int INTERVAL_CYC = 1560,
    parameter int WARMUP_CNT   = 8,
    parameter int DEBT_W       = 3,
    parameter int URGENT_TH    = 2,
    parameter int CSR_CYC      = 1,
    parameter int RAS_CYC      = 6,
    parameter int RP_CYC       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_cbr,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             refresh_urgent,
    output logic             init_done,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             addr_en,
    output logic [ROW_W-1:0] row_addr
);
    dref_phase_e phase;
    logic        tick;
    logic        owed;
    logic        busy;
    logic        done;
    logic        pending;
    logic        start;

    dref_timer #(
        .PAUSE_CYC   (PAUSE_CYC),
        .INTERVAL_CYC(INTERVAL_CYC),
        .WARMUP_CNT  (WARMUP_CNT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_done(done),
        .phase   (phase),
        .tick    (tick)
    );

    dref_debt #(
        .DEBT_W   (DEBT_W),
        .URGENT_TH(URGENT_TH)
    ) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (tick),
        .pay   (done && (phase == PH_RUN)),
        .owed  (owed),
        .urgent(refresh_urgent)
    );

    dref_strobe #(
        .ROW_W  (ROW_W),
        .CSR_CYC(CSR_CYC),
        .RAS_CYC(RAS_CYC),
        .RP_CYC (RP_CYC)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .use_cbr (use_cbr),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .addr_en (addr_en),
        .row_addr(row_addr),
        .busy    (busy),
        .done    (done)
    );

    // Bus arbitration and start condition; WE stays high so no test mode.
    always_comb begin
        pending   = (phase == PH_WARM) || ((phase == PH_RUN) && owed);
        start     = pending && !busy && bus_gnt;
        bus_req   = pending || busy;
        init_done = (phase == PH_RUN);
        we_n      = 1'b1;
    end
endmodule

// File: rtl/dref_sched_chk.sv
// dref_sched_chk: protocol properties of dref_sched, bound to every instance.
// Assumes it sees the top-level ports only.
module dref_sched_chk #(
    parameter int ROW_W     = 10,
    parameter int PAUSE_CYC = 10000,
    parameter int RAS_CYC   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             refresh_urgent,
    input logic             init_done,
    input logic             ras_n,
    input logic             cas_n,
    input logic             addr_en,
    input logic [ROW_W-1:0] row_addr
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int LW = $clog2(RAS_CYC + 2);
    localparam logic [PW-1:0] PAUSE_V = PW'(PAUSE_CYC);
    localparam logic [LW-1:0] LOW_MAX = '1;

    logic [PW-1:0] since_rst;
    logic [LW-1:0] low_len;

    // Cycles since reset release, saturating at the pause length.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_rst <= '0;
        else if (since_rst != PAUSE_V) since_rst <= since_rst + PW'(1);
    end

    // Length of the current or last row strobe pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_len <= '0;
        else if (ras_n)      low_len <= '0;
        else if (low_len != LOW_MAX) low_len <= low_len + LW'(1);
    end

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PAUSE_V) |-> (!bus_req && ras_n && cas_n)); // R2
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_done) |-> init_done); // R3
    AST_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n)); // R4
    AST_CAS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n) && $past(!cas_n)) |-> !cas_n); // R4
    AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n) |-> (addr_en && $past(addr_en) && $stable(row_addr))); // R5
    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && !$past(ras_n) && (low_len != '0)) |-> (low_len == LW'(RAS_CYC))); // R6
    AST_STROBE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> bus_req); // R9
    AST_URGENT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_urgent |-> bus_req); // R10
endmodule

bind dref_sched dref_sched_chk #(
    .ROW_W    (ROW_W),
    .PAUSE_CYC(PAUSE_CYC),
    .RAS_CYC  (RAS_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .refresh_urgent(refresh_urgent),
    .init_done     (init_done),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .addr_en       (addr_en),
    .row_addr      (row_addr)
);

// File: tb/dref_sched_tb_top.sv
// Bench for dref_sched: debt table walk plus directed start-up, form and wrap tests.
module dref_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 10;
    localparam int PAUSE      = 50;
    localparam int IVL        = 64;
    localparam int WARM       = 8;
    localparam int DEBT_W     = 2;
    localparam int URG_TH     = 1;
    localparam int CSR        = 2;
    localparam int RASC       = 6;
    localparam int RPC        = 4;
    localparam int ROWS       = 1 << ROW_W;

    // Debt table: sample point after init (cycles), expected urgent, expected request.
    localparam int NSAMP = 5;
    localparam int SAMP_N   [NSAMP] = '{10, 74, 138, 202, 330};
    localparam bit SAMP_URG [NSAMP] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam bit SAMP_REQ [NSAMP] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             use_cbr = 1'b1;
    logic             bus_gnt = 1'b1;
    logic             bus_req, refresh_urgent, init_done, ras_n, cas_n, we_n, addr_en;
    logic [ROW_W-1:0] row_addr;

    int tests = 0;
    int fails = 0;

    dref_sched #(
        .ROW_W(ROW_W), .PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVL), .WARMUP_CNT(WARM),
        .DEBT_W(DEBT_W), .URGENT_TH(URG_TH), .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RPC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .use_cbr(use_cbr), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .refresh_urgent(refresh_urgent), .init_done(init_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr_en(addr_en), .row_addr(row_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Strobe monitor, sampled on the falling edge.
    int         falls;
    bit         prev_ras, prev_aen, seen_fall, wrap_seen;
    logic [ROW_W-1:0] prev_addr;
    int         cas_low_run, ras_low_run, ras_high_run, exp_row;

    always @(negedge clk) begin
        if (!rst_n) begin
            falls = 0; prev_ras = 1'b1; prev_aen = 1'b0; prev_addr = '0;
            seen_fall = 1'b0; wrap_seen = 1'b0;
            cas_low_run = 0; ras_low_run = 0; ras_high_run = 0; exp_row = 0;
        end else begin
            if (prev_ras && !ras_n) begin
                falls++;
                if (seen_fall)
                    chk(ras_high_run >= RPC, "R6 precharge width", ras_high_run, RPC);
                seen_fall = 1'b1;
                if (use_cbr) begin
                    chk(!cas_n && cas_low_run >= CSR, "R4 cas lead", cas_low_run, CSR);
                    chk(we_n == 1'b1, "R4 we high", int'(we_n), 1);
                end else begin
                    chk(cas_n == 1'b1, "R5 cas idle", int'(cas_n), 1);
                    chk(addr_en && prev_aen && row_addr == prev_addr, "R5 addr setup",
                        int'(row_addr), int'(prev_addr));
                    chk(int'(row_addr) == exp_row, "R7 row sequence", int'(row_addr), exp_row);
                    if (row_addr == '0 && falls > 1) wrap_seen = 1'b1;
                    exp_row = (exp_row + 1) % ROWS;
                end
            end
            if (!prev_ras && ras_n)
                chk(ras_low_run == RASC, "R6 ras width", ras_low_run, RASC);
            if (!ras_n) begin
                if (use_cbr && !prev_ras)
                    chk(!cas_n, "R4 cas hold", int'(cas_n), 0);
                if (!use_cbr)
                    chk(cas_n, "R5 cas high in pulse", int'(cas_n), 1);
            end
            cas_low_run  = cas_n ? 0 : cas_low_run + 1;
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            prev_ras = ras_n; prev_aen = addr_en; prev_addr = row_addr;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        int f0;
        bit quiet;

        // R1: reset state.
        repeat (3) step();
        chk(ras_n && cas_n && we_n, "R1 strobes idle", int'({ras_n, cas_n, we_n}), 7);
        chk(!bus_req && !init_done && !refresh_urgent && !addr_en, "R1 flags low",
            int'({bus_req, init_done, refresh_urgent, addr_en}), 0);

        // R2: start-up pause, internal-counter form.
        rst_n = 1'b1;
        quiet = 1'b1;
        for (int i = 1; i < PAUSE; i++) begin
            step();
            if (bus_req || !ras_n || !cas_n) quiet = 1'b0;
        end
        chk(quiet, "R2 quiet during pause", int'(quiet), 1);
        step();
        chk(bus_req, "R2 request after pause", int'(bus_req), 1);

        // R3: warm-up count before init_done.
        while (!init_done) step();
        chk(falls == WARM, "R3 warm-up count", falls, WARM);
        bus_gnt = 1'b0;
        f0 = falls;

        // R8/R9/R10: debt table walk with the grant withheld.
        n = 0;
        for (int i = 0; i < NSAMP; i++) begin
            while (n < SAMP_N[i]) begin step(); n++; end
            chk(refresh_urgent == SAMP_URG[i], "R10 urgent vs debt",
                int'(refresh_urgent), int'(SAMP_URG[i]));
            chk(bus_req == SAMP_REQ[i], "R9 request vs debt", int'(bus_req), int'(SAMP_REQ[i]));
        end
        chk(falls == f0, "R9 no start without grant", falls - f0, 0);
        chk(init_done, "R3 init_done sticky", int'(init_done), 1);

        // R8: grant returns; saturated debt of 3 drains, nothing else runs.
        bus_gnt = 1'b1;
        while (n < 380) begin step(); n++; end
        chk(falls - f0 == 3, "R8 debt drained at saturation", falls - f0, 3);
        chk(!bus_req && !refresh_urgent, "R8 idle after drain",
            int'({bus_req, refresh_urgent}), 0);

        // Addressed form: restart with row-strobe-only refresh.
        rst_n = 1'b0;
        use_cbr = 1'b0;
        repeat (3) step();
        chk(ras_n && cas_n && !addr_en && !bus_req, "R1 reset after run",
            int'({ras_n, cas_n, addr_en, bus_req}), 12);
        rst_n = 1'b1;
        while (!init_done) step();
        chk(falls == WARM, "R3 warm-up count addressed form", falls, WARM);
        f0 = falls;
        for (int i = 0; i < 10 * IVL + 32; i++) step();
        chk(falls - f0 == 10, "R8 one refresh per interval", falls - f0, 10);

        // R7: run past a full row sweep and confirm the wrap.
        while (falls < ROWS + 6) step();
        chk(wrap_seen, "R7 row counter wrap", int'(wrap_seen), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule